// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the stack-frame half of a subroutine call, a subroutine return and a trap entry. It holds one word-wide data-memory port and works from the stack pointer and frame pointer in effect when it is started. Other inputs give the address of the instruction being executed, a call target and a trap handler vector. Decode starts it with a one-cycle strobe and an operation code. When it finishes, it hands back new stack pointer, frame pointer and program counter values, marked by a done pulse.

A call or trap builds a three-word frame below the stack pointer. The highest word is left unwritten as a spare slot. The return address goes in the middle word and the caller's frame pointer in the lowest word. Both pointers then move to the lowest word. A return reverses this, using the frame pointer as its base rather than the stack pointer. It reloads the frame pointer and the return address from the frame and moves the stack pointer past all three words. The block makes at most one memory access per cycle. If either pointer is not word aligned, it refuses the operation and makes no memory access at all.

Operation codes on `opKind` are: 0 = call with absolute target, 1 = call through a register, 2 = trap entry, 3 = return. Read data on `memRdata` is expected one cycle after a read request.

Top module: `frame_seq`

## Requirements
- R1: After reset, `busy`, `done`, `errFlag` and `memReq` are 0, and `spOut`, `fpOut` and `pcOut` are 0.
- R2: For an accepted call or trap with stack pointer S, the first cycle after the start edge writes the return address to S-8. The next cycle writes the start-time frame pointer to S-12. The word at S-4 is never written.
- R3: The return address is the instruction address plus 6 for opKind 0 and opKind 2, and the instruction address plus 2 for opKind 1.
- R4: When a call or trap completes, `spOut` and `fpOut` both equal S-12. `pcOut` equals `callTarget` for opKind 0 and 1, and `trapVector` for opKind 2.
- R5: For an accepted return with frame pointer F, the first cycle after the start edge reads F and the next cycle reads F+4. On completion, `fpOut` is the word read from F, `pcOut` is the word read from F+4, and `spOut` is F+12.
- R6: At most one memory access is presented per cycle, and `memReq` is high only while `busy` is high.
- R7: `busy` is high from the cycle after the start edge through the register-update cycle: 3 cycles for a call or trap, 4 cycles for a return. In the cycle after `busy` falls, `done` is high for exactly one cycle, and the new `spOut`, `fpOut` and `pcOut` are visible in that cycle.
- R8: If `spIn` or `fpIn` has either of its two low bits set at the start edge, the cycle after the start edge shows `done`=1 and `errFlag`=1. No memory request is made, `busy` stays low, and `spOut`, `fpOut` and `pcOut` keep their previous values.
- R9: A start strobe that arrives while an operation is in progress is ignored. The running sequence, its addresses and its results are unchanged, and no second operation follows it.
- R10: `errFlag` holds until the next accepted start with aligned pointers, and that start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| opKind | input | 2 | 0 call absolute, 1 call register, 2 trap, 3 return |
| spIn | input | 32 | Stack pointer at start |
| fpIn | input | 32 | Frame pointer at start |
| instAddr | input | 32 | Address of the call or trap instruction |
| callTarget | input | 32 | Jump target for calls |
| trapVector | input | 32 | Handler address for trap entry |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last accepted start had a misaligned pointer |
| spOut | output | 32 | Updated stack pointer |
| fpOut | output | 32 | Updated frame pointer |
| pcOut | output | 32 | Next program counter |

## Verification
Each random call uses a random aligned stack pointer, frame pointer, instruction address, target and vector. The matching return is then started from the frame pointer the call produced. This round trip shows whether the push order and the pop order agree: a swapped slot or a wrong base returns the wrong frame pointer or program counter. All three call kinds are mixed so that the two return-address offsets and the handler selection can be told apart. Directed cases cover misaligned stack and frame pointers, a second start during a busy sequence, and the error flag clearing. A sentinel word placed in the spare slot before each call shows whether it is ever overwritten.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    OP_CALL_ABS = 2'd0,
    OP_CALL_REG = 2'd1,
    OP_TRAP     = 2'd2,
    OP_RETURN   = 2'd3
  } opKind_t;

  typedef struct packed {
    logic load;
    logic wrRa;
    logic wrFp;
    logic rdFp;
    logic rdRa;
    logic capFp;
    logic capRa;
    logic commitCall;
    logic commitRet;
    logic setErr;
  } frameCtl_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic [1:0] opKind,
  input  logic      misaligned,
  output frameCtl_t ctl,
  output logic      busy,
  output logic      done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_RA, ST_PUSH_FP, ST_POP_FP, ST_POP_RA, ST_POP_WAIT,
    ST_COMMIT, ST_FIN
  } state_t;

  state_t state, nextState;
  logic   retMode;
  logic   accept;

  assign accept = start && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      retMode <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) retMode <= (opKind == OP_RETURN);
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (misaligned) begin
            ctl.setErr = 1'b1;
            nextState  = ST_FIN;
          end else begin
            ctl.load  = 1'b1;
            nextState = (opKind == OP_RETURN) ? ST_POP_FP : ST_PUSH_RA;
          end
        end
      end
      ST_PUSH_RA:  begin ctl.wrRa = 1'b1; nextState = ST_PUSH_FP; end
      ST_PUSH_FP:  begin ctl.wrFp = 1'b1; nextState = ST_COMMIT; end
      ST_POP_FP:   begin ctl.rdFp = 1'b1; nextState = ST_POP_RA; end
      ST_POP_RA:   begin ctl.rdRa = 1'b1; ctl.capFp = 1'b1; nextState = ST_POP_WAIT; end
      ST_POP_WAIT: begin ctl.capRa = 1'b1; nextState = ST_COMMIT; end
      ST_COMMIT: begin
        ctl.commitCall = !retMode;
        ctl.commitRet  = retMode;
        nextState      = ST_FIN;
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_FIN);
  assign done = (state == ST_FIN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_BUSY_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7
  AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setErr |=> (!busy && done)); // R8
endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LONG_RA  = 6,
  parameter int SHORT_RA = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  frameCtl_t       ctl,
  input  logic [1:0]      opKind,
  input  logic [XLEN-1:0] spIn,
  input  logic [XLEN-1:0] fpIn,
  input  logic [XLEN-1:0] instAddr,
  input  logic [XLEN-1:0] callTarget,
  input  logic [XLEN-1:0] trapVector,
  input  logic [XLEN-1:0] memRdata,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic [XLEN-1:0] spOut,
  output logic [XLEN-1:0] fpOut,
  output logic [XLEN-1:0] pcOut,
  output logic            errFlag,
  output logic            misaligned
);
  localparam int SLOT       = XLEN / 8;
  localparam int ALIGN_BITS = $clog2(SLOT);
  localparam logic [XLEN-1:0] SLOT_V  = XLEN'(SLOT);
  localparam logic [XLEN-1:0] FRAME_V = XLEN'(3 * SLOT);

  logic [XLEN-1:0] spLat, fpLat, raLat, tgtLat, popFp, popRa;

  assign misaligned = (|spIn[ALIGN_BITS-1:0]) || (|fpIn[ALIGN_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spLat   <= '0;
      fpLat   <= '0;
      raLat   <= '0;
      tgtLat  <= '0;
      popFp   <= '0;
      popRa   <= '0;
      spOut   <= '0;
      fpOut   <= '0;
      pcOut   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (ctl.setErr) errFlag <= 1'b1;
      if (ctl.load) begin
        errFlag <= 1'b0;
        spLat   <= spIn;
        fpLat   <= fpIn;
        raLat   <= instAddr + ((opKind == OP_CALL_REG) ? XLEN'(SHORT_RA) : XLEN'(LONG_RA));
        tgtLat  <= (opKind == OP_TRAP) ? trapVector : callTarget;
      end
      if (ctl.capFp) popFp <= memRdata;
      if (ctl.capRa) popRa <= memRdata;
      if (ctl.commitCall) begin
        spOut <= spLat - FRAME_V;
        fpOut <= spLat - FRAME_V;
        pcOut <= tgtLat;
      end
      if (ctl.commitRet) begin
        spOut <= fpLat + FRAME_V;
        fpOut <= popFp;
        pcOut <= popRa;
      end
    end
  end

  always_comb begin
    memReq   = ctl.wrRa | ctl.wrFp | ctl.rdFp | ctl.rdRa;
    memWe    = ctl.wrRa | ctl.wrFp;
    memAddr  = '0;
    memWdata = '0;
    if (ctl.wrRa) begin
      memAddr  = spLat - (SLOT_V + SLOT_V);
      memWdata = raLat;
    end else if (ctl.wrFp) begin
      memAddr  = spLat - FRAME_V;
      memWdata = fpLat;
    end else if (ctl.rdFp) begin
      memAddr = fpLat;
    end else if (ctl.rdRa) begin
      memAddr = fpLat + SLOT_V;
    end
  end

  AST_ALIGNED_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[ALIGN_BITS-1:0] == '0)); // R8
  AST_SLOT_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr != spLat - SLOT_V)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrRa, ctl.wrFp, ctl.rdFp, ctl.rdRa})); // R6
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LONG_RA  = 6,
  parameter int SHORT_RA = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      opKind,
  input  logic [XLEN-1:0] spIn,
  input  logic [XLEN-1:0] fpIn,
  input  logic [XLEN-1:0] instAddr,
  input  logic [XLEN-1:0] callTarget,
  input  logic [XLEN-1:0] trapVector,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  output logic            busy,
  output logic            done,
  output logic            errFlag,
  output logic [XLEN-1:0] spOut,
  output logic [XLEN-1:0] fpOut,
  output logic [XLEN-1:0] pcOut
);
  frameCtl_t ctl;
  logic      misaligned;

  frame_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind),
    .misaligned(misaligned), .ctl(ctl), .busy(busy), .done(done)
  );

  frame_datapath #(.XLEN(XLEN), .LONG_RA(LONG_RA), .SHORT_RA(SHORT_RA)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opKind(opKind), .spIn(spIn), .fpIn(fpIn),
    .instAddr(instAddr), .callTarget(callTarget), .trapVector(trapVector),
    .memRdata(memRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .spOut(spOut), .fpOut(fpOut), .pcOut(pcOut),
    .errFlag(errFlag), .misaligned(misaligned)
  );

  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy); // R6
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (done && errFlag) |-> !memReq); // R8
endmodule

// File: tb/frame_seq_test.sv
module frame_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [31:0] spIn = '0, fpIn = '0, instAddr = '0, callTarget = '0, trapVector = '0;
  logic memReq, memWe, busy, done, errFlag;
  logic [31:0] memAddr, memWdata, spOut, fpOut, pcOut;
  logic [31:0] memRdata = '0;
  logic [31:0] mem [0:1023];
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  frame_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .spIn(spIn), .fpIn(fpIn),
    .instAddr(instAddr), .callTarget(callTarget), .trapVector(trapVector),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .errFlag(errFlag),
    .spOut(spOut), .fpOut(fpOut), .pcOut(pcOut)
  );

  always_ff @(posedge clk) begin
    if (memReq && memWe) mem[memAddr[11:2]] <= memWdata;
    if (memReq && !memWe) memRdata <= mem[memAddr[11:2]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRa(input logic [1:0] k, input logic [31:0] ia);
    return (k == 2'd1) ? ia + 32'd2 : ia + 32'd6;
  endfunction

  // Call or trap; sequence checked cycle by cycle. extraStart re-raises start while busy (R9).
  task automatic runCall(input logic [1:0] k, input logic [31:0] sp, input logic [31:0] fp,
                         input logic [31:0] ia, input logic [31:0] tg, input logic [31:0] tv,
                         input bit extraStart);
    logic [31:0] ra, slot;
    ra = expRa(k, ia);
    mem[(sp - 32'd4) >> 2] = 32'hA5A5_0000 ^ sp;
    slot = mem[(sp - 32'd4) >> 2];
    @(negedge clk);
    opKind = k; spIn = sp; fpIn = fp; instAddr = ia; callTarget = tg; trapVector = tv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(memReq && memWe && busy, "R2 ra write req", {29'd0, memReq, memWe, busy}, 32'd7);
    chk(memAddr == sp - 32'd8, "R2 ra addr", memAddr, sp - 32'd8);
    chk(memWdata == ra, "R3 return address", memWdata, ra);
    if (extraStart) begin opKind = 2'd3; fpIn = 32'h40; start = 1'b1; end
    @(negedge clk);
    start = 1'b0;
    chk(memReq && memWe, "R2 fp write req", {30'd0, memReq, memWe}, 32'd3);
    chk(memAddr == sp - 32'd12, "R2 fp addr", memAddr, sp - 32'd12);
    chk(memWdata == fp, "R2 fp data", memWdata, fp);
    @(negedge clk);
    chk(busy && !memReq && !done, "R7 update cycle", {30'd0, busy, done}, 32'd2);
    @(negedge clk);
    chk(done && !busy && !errFlag, "R7 done pulse", {29'd0, done, busy, errFlag}, 32'd4);
    chk(spOut == sp - 32'd12, "R4 spOut", spOut, sp - 32'd12);
    chk(fpOut == sp - 32'd12, "R4 fpOut", fpOut, sp - 32'd12);
    chk(pcOut == ((k == 2'd2) ? tv : tg), "R4 pcOut", pcOut, (k == 2'd2) ? tv : tg);
    chk(mem[(sp - 32'd4) >> 2] == slot, "R2 slot untouched", mem[(sp - 32'd4) >> 2], slot);
    @(negedge clk);
    chk(!done && !busy, "R9 no second op", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic runRet(input logic [31:0] fp, input logic [31:0] expFp, input logic [31:0] expPc);
    @(negedge clk);
    opKind = 2'd3; fpIn = fp; spIn = 32'h0000_0100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(memReq && !memWe && memAddr == fp, "R5 read fp addr", memAddr, fp);
    @(negedge clk);
    chk(memReq && !memWe && memAddr == fp + 32'd4, "R5 read ra addr", memAddr, fp + 32'd4);
    @(negedge clk);
    chk(busy && !memReq, "R7 return wait", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk(busy && !done, "R7 return update", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk(done && !busy, "R7 return done", {31'd0, done}, 32'd1);
    chk(fpOut == expFp, "R5 fpOut", fpOut, expFp);
    chk(pcOut == expPc, "R5 pcOut", pcOut, expPc);
    chk(spOut == fp + 32'd12, "R5 spOut", spOut, fp + 32'd12);
  endtask

  task automatic runBad(input logic [1:0] k, input logic [31:0] sp, input logic [31:0] fp);
    logic [31:0] s0, f0, p0;
    s0 = spOut; f0 = fpOut; p0 = pcOut;
    @(negedge clk);
    opKind = k; spIn = sp; fpIn = fp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && errFlag && !busy && !memReq, "R8 error done",
        {28'd0, done, errFlag, busy, memReq}, 32'hC);
    chk(spOut == s0 && fpOut == f0 && pcOut == p0, "R8 outputs held", spOut, s0);
    @(negedge clk);
    chk(errFlag && !memReq, "R10 error held", {31'd0, errFlag}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !errFlag && !memReq, "R1 reset flags",
        {28'd0, busy, done, errFlag, memReq}, 32'd0);
    chk(spOut == 0 && fpOut == 0 && pcOut == 0, "R1 reset outputs", spOut | fpOut | pcOut, 32'd0);
    rstN = 1'b1;
    // directed: each call kind with roundtrip
    for (int k = 0; k < 3; k++) begin
      runCall(2'(k), 32'h800, 32'h900, 32'h1000, 32'h2000, 32'h3000, 1'b0);
      runRet(32'h7F4, 32'h900, expRa(2'(k), 32'h1000));
    end
    // R9: start during busy
    runCall(2'd0, 32'h400, 32'h500, 32'h10, 32'h20, 32'h30, 1'b1);
    // R8 / R10
    runBad(2'd0, 32'h402, 32'h500);
    runBad(2'd3, 32'h400, 32'h501);
    runCall(2'd1, 32'h600, 32'h700, 32'h44, 32'h88, 32'hCC, 1'b0); // R10 cleared
    // random roundtrips
    for (int n = 0; n < 40; n++) begin
      logic [31:0] sp, fp, ia, tg, tv;
      logic [1:0] k;
      k  = 2'($urandom_range(0, 2));
      sp = {20'd0, 10'($urandom_range(16, 1023)), 2'b00};
      fp = {20'd0, 10'($urandom_range(0, 1023)), 2'b00};
      ia = $urandom; tg = $urandom; tv = $urandom;
      runCall(k, sp, fp, ia, tg, tv, 1'b0);
      runRet(sp - 32'd12, fp, expRa(k, ia));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule